// File: doc/BRIEF.md
# Split Single-Line First-Level Cache Front-End

This block sits between a CPU core and a larger two-way second-level cache, which has one instance for instructions and one for data. It keeps two cache lines in flip-flops: one for instruction fetches and one for data. Alternating between code and data accesses therefore never throws a line out. Each CPU request is classified on the clock edge where it is accepted. The classification is internal (no memory), instruction fetch, data read or data write. The block then decides whether the access is served from its own registers or must go to the second level. It raises a one-cycle continue strobe after the number of fast clock cycles that the serving path needs.

On a read miss, the block sends a single-cycle read request to the second-level instance that matches the access type. It then waits for the whole line to come back on the fill bus. The full line and its tag are replaced, and the line is marked valid. Every write goes through to the second level. A write that hits the data line also patches the stored word. A write never allocates a line. An invalidate input empties both lines.

Top module: `l1_split_front`

## Requirements
- R1: After reset the strobes `cont`, `l2_rd` and `l2_wr` are low and both lines are invalid, so the first instruction fetch and the first data read both miss.
- R2: A request is taken only on an edge where the block is idle. A `req_valid` seen while an access is in progress is ignored: it produces no second-level traffic and changes no line contents.
- R3: An internal access (`req_kind` = 0) raises `cont` exactly 3 cycles after the accepting edge and causes no second-level traffic.
- R4: An instruction fetch (`req_kind` = 1) or data read (`req_kind` = 2) that hits its line raises `cont` exactly 4 cycles after the accepting edge, and `rdata` then holds the addressed word.
- R5: A read miss pulses `l2_rd` for one cycle right after the accepting edge, with `l2_addr` = request address and `l2_instr` = 1 for fetches and 0 for data. `cont` rises at edge max(6, F+1) after acceptance, where F is the edge at which `l2_fill_valid` is sampled. `rdata` then holds the addressed word of the returned line.
- R6: The instruction line and the data line are independent: a data miss does not evict the instruction line, and a fetch miss does not evict the data line.
- R7: A write (`req_kind` = 3) raises `cont` 4 cycles after acceptance and pulses `l2_wr` for one cycle right after the accepting edge, carrying the address and data. A write hit updates the word in the data line. A write miss leaves the data line unchanged and never requests a fill.
- R8: A fill replaces the whole line together with its tag, so an address from the previous tag misses afterwards.
- R9: An `inval` pulse clears both valid bits, so the next fetch and the next data read both miss.
- R10: `l2_fill_valid` has no effect unless a read miss is waiting for its line.
- R11: With default parameters a line holds 4 words of 32 bits. Address bits [3:2] pick the word, bits [31:4] form the tag, and fill-bus word w sits at bits [32w+31:32w].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| inval | input | 1 | Clears both line valid bits |
| req_valid | input | 1 | CPU request strobe |
| req_kind | input | 2 | 0 internal, 1 instruction fetch, 2 data read, 3 data write |
| req_addr | input | ADDR_W | Byte address of the access |
| req_wdata | input | DATA_W | Write data |
| cont | output | 1 | One-cycle CPU continue strobe |
| rdata | output | DATA_W | Read data, valid from the `cont` cycle until the next read completes |
| l2_rd | output | 1 | One-cycle line read request to the second level |
| l2_wr | output | 1 | One-cycle write-through request to the second level |
| l2_instr | output | 1 | Selects the instruction (1) or data (0) second-level instance |
| l2_addr | output | ADDR_W | Address for `l2_rd` / `l2_wr` |
| l2_wdata | output | DATA_W | Data for `l2_wr` |
| l2_fill_valid | input | 1 | Fill line present on `l2_fill_line` |
| l2_fill_line | input | WORDS*DATA_W | Returned cache line |

## Verification
The accepting edge is counted as edge 0. Second-level request pulses are due in the cycle right after edge 0. `cont` is due after edge 3, 4 or 6 for internal, hit/write and fast-miss accesses, and after the edge following the fill for a slow second level. The bench counts every rising edge after acceptance and samples all outputs on the following falling edge. It records the edge number at which `cont` appears and compares it with the required count. Each `l2_rd`/`l2_wr` sighting is logged against its edge, and the fill is driven so that it is sampled at a chosen edge. Hit-or-miss state that cannot be seen directly is brought out by a later read and observed through its latency and its `l2_rd` pulse.

// File: rtl/l1f_pkg.sv
package l1f_pkg;
  typedef enum logic [1:0] {
    ACC_INT    = 2'd0,
    ACC_IFETCH = 2'd1,
    ACC_DREAD  = 2'd2,
    ACC_WRITE  = 2'd3
  } acc_kind_e;

  localparam int LINE_I = 0;
  localparam int LINE_D = 1;
  localparam int NLINES = 2;
endpackage

// File: rtl/l1f_rst_sync.sv
module l1f_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/l1f_line.sv
module l1f_line #(
  parameter int TAG_W  = 28,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int IDX_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    inval,
  input  logic [TAG_W-1:0]        look_tag,
  input  logic [IDX_W-1:0]        rd_idx,
  input  logic                    fill_en,
  input  logic [TAG_W-1:0]        fill_tag,
  input  logic [WORDS*DATA_W-1:0] fill_line,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [DATA_W-1:0]       wr_data,
  output logic                    hit,
  output logic [DATA_W-1:0]       rd_word,
  output logic                    valid
);
  logic              valid_q, valid_d;
  logic [TAG_W-1:0]  tag_q, tag_d;
  logic [DATA_W-1:0] data_q [WORDS];
  logic [DATA_W-1:0] data_d [WORDS];
  logic              data_en;

  assign data_en = fill_en | wr_en;

  always_comb begin
    valid_d = valid_q;
    tag_d   = tag_q;
    for (int w = 0; w < WORDS; w++) data_d[w] = data_q[w];
    if (fill_en) begin
      valid_d = 1'b1;
      tag_d   = fill_tag;
      for (int w = 0; w < WORDS; w++) data_d[w] = fill_line[w*DATA_W +: DATA_W];
    end
    if (wr_en) data_d[wr_idx] = wr_data;
    if (inval) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q <= tag_d;
    if (data_en) for (int w = 0; w < WORDS; w++) data_q[w] <= data_d[w];
  end

  assign hit     = valid_q && (tag_q == look_tag);
  assign rd_word = data_q[rd_idx];
  assign valid   = valid_q;
endmodule

// File: rtl/l1f_timer.sv
module l1f_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] target,
  input  logic             ready,
  output logic             busy,
  output logic             fire,
  output logic             cont
);
  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] target_q;
  logic             cont_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    fire   = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        cnt_d  = CNT_W'(1);
      end
    end else if ((cnt_q >= target_q) && ready) begin
      fire   = 1'b1;
      busy_d = 1'b0;
    end else if (cnt_q != {CNT_W{1'b1}}) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      cont_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      cont_q <= fire;
    end
  end

  always_ff @(posedge clk) begin
    if (start && !busy_q) target_q <= target;
  end

  assign busy = busy_q;
  assign cont = cont_q;
endmodule

// File: rtl/l1_split_front.sv
module l1_split_front
  import l1f_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int WORDS   = 4,
  parameter int INT_CYC = 3,
  parameter int HIT_CYC = 4,
  parameter int WR_CYC  = 4,
  parameter int L2_CYC  = 6,
  parameter int CNT_W   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    inval,
  input  logic                    req_valid,
  input  logic [1:0]              req_kind,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [DATA_W-1:0]       req_wdata,
  output logic                    cont,
  output logic [DATA_W-1:0]       rdata,
  output logic                    l2_rd,
  output logic                    l2_wr,
  output logic                    l2_instr,
  output logic [ADDR_W-1:0]       l2_addr,
  output logic [DATA_W-1:0]       l2_wdata,
  input  logic                    l2_fill_valid,
  input  logic [WORDS*DATA_W-1:0] l2_fill_line
);
  localparam int BOFF_W = $clog2(DATA_W / 8);
  localparam int IDX_W  = $clog2(WORDS);
  localparam int TAG_W  = ADDR_W - BOFF_W - IDX_W;

  logic rst_n_s;
  l1f_rst_sync i_rst (.clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s));

  acc_kind_e        kind_in, kind_q, kind_d;
  logic [TAG_W-1:0] req_tag, tag_q, tag_d;
  logic [IDX_W-1:0] req_idx, idx_q, idx_d;
  logic             busy, fire, accept, is_rd, is_wr, miss_rd, wr_hit;
  logic             req_line, line_q;
  logic [CNT_W-1:0] target;
  logic [NLINES-1:0] line_hit, line_valid;
  logic [DATA_W-1:0] line_word [NLINES];

  logic              l2_rd_q, l2_rd_d, l2_wr_q, l2_wr_d, l2_instr_q, l2_instr_d;
  logic              fill_pend_q, fill_pend_d;
  logic [ADDR_W-1:0] l2_addr_q, l2_addr_d;
  logic [DATA_W-1:0] l2_wdata_q, l2_wdata_d, rdata_q, rdata_d;

  assign kind_in  = acc_kind_e'(req_kind);
  assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
  assign req_idx  = req_addr[BOFF_W +: IDX_W];
  assign accept   = req_valid && !busy;
  assign is_rd    = (kind_in == ACC_IFETCH) || (kind_in == ACC_DREAD);
  assign is_wr    = (kind_in == ACC_WRITE);
  assign req_line = (kind_in != ACC_IFETCH);
  assign line_q   = (kind_q != ACC_IFETCH);
  assign miss_rd  = accept && is_rd && !line_hit[req_line];
  assign wr_hit   = accept && is_wr && line_hit[LINE_D];

  always_comb begin
    unique case (kind_in)
      ACC_INT:   target = CNT_W'(INT_CYC);
      ACC_WRITE: target = CNT_W'(WR_CYC);
      default:   target = line_hit[req_line] ? CNT_W'(HIT_CYC) : CNT_W'(L2_CYC);
    endcase
  end

  generate
    for (genvar g = 0; g < NLINES; g++) begin : g_line
      l1f_line #(.TAG_W(TAG_W), .DATA_W(DATA_W), .WORDS(WORDS), .IDX_W(IDX_W)) i_line (
        .clk      (clk),
        .rst_n    (rst_n_s),
        .inval    (inval),
        .look_tag (req_tag),
        .rd_idx   (idx_q),
        .fill_en  (fill_pend_q && l2_fill_valid && (line_q == 1'(g))),
        .fill_tag (tag_q),
        .fill_line(l2_fill_line),
        .wr_en    ((g == LINE_D) && wr_hit),
        .wr_idx   (req_idx),
        .wr_data  (req_wdata),
        .hit      (line_hit[g]),
        .rd_word  (line_word[g]),
        .valid    (line_valid[g])
      );
    end
  endgenerate

  l1f_timer #(.CNT_W(CNT_W)) i_timer (
    .clk   (clk),
    .rst_n (rst_n_s),
    .start (req_valid),
    .target(target),
    .ready (!fill_pend_q),
    .busy  (busy),
    .fire  (fire),
    .cont  (cont)
  );

  always_comb begin
    kind_d      = kind_q;
    tag_d       = tag_q;
    idx_d       = idx_q;
    l2_addr_d   = l2_addr_q;
    l2_wdata_d  = l2_wdata_q;
    l2_instr_d  = l2_instr_q;
    rdata_d     = rdata_q;
    l2_rd_d     = miss_rd;
    l2_wr_d     = accept && is_wr;
    fill_pend_d = fill_pend_q;
    if (accept) begin
      kind_d     = kind_in;
      tag_d      = req_tag;
      idx_d      = req_idx;
      l2_addr_d  = req_addr;
      l2_instr_d = (kind_in == ACC_IFETCH);
      if (is_wr) l2_wdata_d = req_wdata;
    end
    if (miss_rd)            fill_pend_d = 1'b1;
    else if (l2_fill_valid) fill_pend_d = 1'b0;
    if (fire && ((kind_q == ACC_IFETCH) || (kind_q == ACC_DREAD)))
      rdata_d = line_word[line_q];
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      kind_q      <= ACC_INT;
      l2_rd_q     <= 1'b0;
      l2_wr_q     <= 1'b0;
      l2_instr_q  <= 1'b0;
      fill_pend_q <= 1'b0;
    end else begin
      kind_q      <= kind_d;
      l2_rd_q     <= l2_rd_d;
      l2_wr_q     <= l2_wr_d;
      l2_instr_q  <= l2_instr_d;
      fill_pend_q <= fill_pend_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      tag_q     <= tag_d;
      idx_q     <= idx_d;
      l2_addr_q <= l2_addr_d;
    end
    if (accept && is_wr) l2_wdata_q <= l2_wdata_d;
    if (fire) rdata_q <= rdata_d;
  end

  assign rdata    = rdata_q;
  assign l2_rd    = l2_rd_q;
  assign l2_wr    = l2_wr_q;
  assign l2_instr = l2_instr_q;
  assign l2_addr  = l2_addr_q;
  assign l2_wdata = l2_wdata_q;
endmodule

// File: rtl/l1_split_front_chk.sv
module l1_split_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       inval,
  input logic       req_valid,
  input logic [1:0] req_kind,
  input logic       busy,
  input logic       cont,
  input logic       l2_rd,
  input logic       l2_wr,
  input logic [1:0] line_valid
);
  AST_CONT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cont |=> !cont); // R4
  AST_L2_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    l2_rd |=> !l2_rd); // R5
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(l2_rd && l2_wr)); // R7
  AST_INT_NO_L2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && req_kind == 2'd0) |=> !(l2_rd || l2_wr)); // R3
  AST_WR_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && req_kind == 2'd3) |=> !l2_rd); // R7
  AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && busy) |=> !(l2_rd || l2_wr)); // R2
  AST_INVAL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    inval |=> (line_valid == 2'b00)); // R9
endmodule

bind l1_split_front l1_split_front_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .inval     (inval),
  .req_valid (req_valid),
  .req_kind  (req_kind),
  .busy      (busy),
  .cont      (cont),
  .l2_rd     (l2_rd),
  .l2_wr     (l2_wr),
  .line_valid(line_valid)
);

// File: tb/test_l1_split_front.sv
`timescale 1ns/1ps
module test_l1_split_front;
  logic         clk = 1'b0;
  logic         rst_n, inval, req_valid, l2_fill_valid;
  logic [1:0]   req_kind;
  logic [31:0]  req_addr, req_wdata, rdata, l2_addr, l2_wdata;
  logic [127:0] l2_fill_line;
  logic         cont, l2_rd, l2_wr, l2_instr;

  int tests = 0;
  int fails = 0;

  // observations of the last access
  int          o_edge, o_nrd, o_nwr, o_rd_edge, o_wr_edge;
  logic [31:0] o_rdata, o_addr, o_wdata;
  logic        o_instr;
  logic [31:0] salt;

  always #2.5 clk = ~clk;

  l1_split_front i_l1_split_front (
    .clk(clk), .rst_n(rst_n), .inval(inval), .req_valid(req_valid),
    .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
    .cont(cont), .rdata(rdata), .l2_rd(l2_rd), .l2_wr(l2_wr),
    .l2_instr(l2_instr), .l2_addr(l2_addr), .l2_wdata(l2_wdata),
    .l2_fill_valid(l2_fill_valid), .l2_fill_line(l2_fill_line)
  );

  function automatic logic [31:0] fw(input logic [31:0] a, input int w, input logic [31:0] s);
    return ({a[31:4], 4'h0} | 32'(w * 4)) ^ s;
  endfunction

  function automatic logic [127:0] fline(input logic [31:0] a, input logic [31:0] s);
    logic [127:0] l;
    for (int w = 0; w < 4; w++) l[w*32 +: 32] = fw(a, w, s);
    return l;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  // One access; accepting edge is edge 0; outputs sampled on falling edges.
  task automatic access(input logic [1:0] kind, input logic [31:0] addr,
                        input logic [31:0] wd, input int fill_delay, input bit poke);
    int fill_at;
    bit done;
    fill_at = -100; done = 0;
    o_edge = -1; o_nrd = 0; o_nwr = 0; o_rd_edge = -1; o_wr_edge = -1;
    req_valid = 1'b1; req_kind = kind; req_addr = addr; req_wdata = wd;
    @(posedge clk); @(negedge clk);
    for (int n = 0; n < 40 && !done; n++) begin
      if (n > 0) begin @(posedge clk); @(negedge clk); end
      req_valid = 1'b0;
      if (poke && n == 0) begin
        req_valid = 1'b1; req_kind = 2'd3; req_addr = addr; req_wdata = 32'hBAD0_BAD0;
      end
      if (l2_rd) begin
        o_nrd++; o_rd_edge = n; o_addr = l2_addr; o_instr = l2_instr;
        fill_at = n + fill_delay;
        l2_fill_line = fline(addr, salt);
      end
      if (l2_wr) begin
        o_nwr++; o_wr_edge = n; o_addr = l2_addr; o_wdata = l2_wdata;
      end
      l2_fill_valid = (fill_at == n + 1);
      if (cont) begin
        o_edge = n; o_rdata = rdata; done = 1;
      end
    end
    req_valid = 1'b0; l2_fill_valid = 1'b0;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset;
    chk(cont == 1'b0, "R1", "cont after reset", 32'(cont), 0);
    chk(l2_rd == 1'b0 && l2_wr == 1'b0, "R1", "l2 strobes after reset", 32'({l2_rd, l2_wr}), 0);
  endtask

  task automatic t_first_miss;
    access(2'd1, 32'h0000_0100, 0, 2, 0);
    chk(o_nrd == 1 && o_rd_edge == 0, "R1", "first fetch misses, l2_rd after edge 0", 32'(o_nrd), 1);
    chk(o_addr == 32'h100 && o_instr == 1'b1, "R5", "fetch miss l2_addr/l2_instr", o_addr, 32'h100);
    chk(o_edge == 6, "R5", "fetch miss cont edge", 32'(o_edge), 6);
    chk(o_rdata == fw(32'h100, 0, salt), "R5", "fetch miss rdata", o_rdata, fw(32'h100, 0, salt));
  endtask

  task automatic t_fetch_hit;
    access(2'd1, 32'h0000_0108, 0, 2, 0);
    chk(o_edge == 4 && o_nrd == 0, "R4", "fetch hit cont edge", 32'(o_edge), 4);
    chk(o_rdata == fw(32'h100, 2, salt), "R11", "word select by bits 3:2", o_rdata, fw(32'h100, 2, salt));
  endtask

  task automatic t_split;
    access(2'd2, 32'h0000_2004, 0, 2, 0);
    chk(o_edge == 6 && o_nrd == 1 && o_instr == 1'b0, "R5", "data miss edge/instance", 32'(o_edge), 6);
    chk(o_rdata == fw(32'h2000, 1, salt), "R5", "data miss rdata", o_rdata, fw(32'h2000, 1, salt));
    access(2'd1, 32'h0000_010C, 0, 2, 0);
    chk(o_edge == 4 && o_nrd == 0, "R6", "fetch line survives data miss", 32'(o_edge), 4);
    access(2'd2, 32'h0000_200C, 0, 2, 0);
    chk(o_edge == 4 && o_rdata == fw(32'h2000, 3, salt), "R6", "data line survives fetch", o_rdata, fw(32'h2000, 3, salt));
  endtask

  task automatic t_slow_l2;
    access(2'd2, 32'h0000_3000, 0, 8, 0);
    chk(o_edge == 9, "R5", "slow fill: cont one edge after fill", 32'(o_edge), 9);
    chk(o_rdata == fw(32'h3000, 0, salt), "R5", "slow fill rdata", o_rdata, fw(32'h3000, 0, salt));
  endtask

  task automatic t_internal;
    access(2'd0, 32'h0000_3000, 0, 2, 0);
    chk(o_edge == 3, "R3", "internal cont edge", 32'(o_edge), 3);
    chk(o_nrd == 0 && o_nwr == 0, "R3", "internal has no l2 traffic", 32'(o_nrd + o_nwr), 0);
  endtask

  task automatic t_write_hit;
    access(2'd3, 32'h0000_3004, 32'hDEAD_BEEF, 2, 0);
    chk(o_edge == 4, "R7", "write cont edge", 32'(o_edge), 4);
    chk(o_nwr == 1 && o_wr_edge == 0 && o_nrd == 0, "R7", "write-through pulse", 32'(o_nwr), 1);
    chk(o_addr == 32'h3004 && o_wdata == 32'hDEAD_BEEF, "R7", "write-through data", o_wdata, 32'hDEAD_BEEF);
    access(2'd2, 32'h0000_3004, 0, 2, 0);
    chk(o_edge == 4 && o_rdata == 32'hDEAD_BEEF, "R7", "write hit updates line", o_rdata, 32'hDEAD_BEEF);
  endtask

  task automatic t_write_miss;
    access(2'd3, 32'h0000_5000, 32'h1234_5678, 2, 0);
    chk(o_edge == 4 && o_nwr == 1 && o_nrd == 0, "R7", "write miss: no fill", 32'(o_nrd), 0);
    access(2'd2, 32'h0000_3008, 0, 2, 0);
    chk(o_edge == 4 && o_nrd == 0, "R7", "write miss keeps data line", 32'(o_edge), 4);
    access(2'd2, 32'h0000_5000, 0, 2, 0);
    chk(o_nrd == 1 && o_edge == 6, "R7", "write miss did not allocate", 32'(o_nrd), 1);
    access(2'd2, 32'h0000_3004, 0, 2, 0);
    chk(o_nrd == 1 && o_edge == 6, "R8", "refill replaced old tag", 32'(o_nrd), 1);
  endtask

  task automatic t_busy_ignore;
    access(2'd2, 32'h0000_3004, 0, 2, 1);
    chk(o_edge == 4 && o_nwr == 0, "R2", "request while busy: no l2_wr", 32'(o_nwr), 0);
    access(2'd2, 32'h0000_3004, 0, 2, 0);
    chk(o_rdata == fw(32'h3000, 1, salt), "R2", "request while busy left line intact", o_rdata, fw(32'h3000, 1, salt));
  endtask

  task automatic t_stray_fill;
    l2_fill_line = fline(32'h7000, 32'h5555_AAAA);
    l2_fill_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    l2_fill_valid = 1'b0;
    access(2'd2, 32'h0000_7000, 0, 2, 0);
    chk(o_nrd == 1 && o_edge == 6, "R10", "stray fill ignored, read misses", 32'(o_nrd), 1);
    chk(o_rdata == fw(32'h7000, 0, salt), "R10", "data from real fill", o_rdata, fw(32'h7000, 0, salt));
  endtask

  task automatic t_inval;
    inval = 1'b1;
    @(posedge clk); @(negedge clk);
    inval = 1'b0;
    access(2'd1, 32'h0000_0100, 0, 2, 0);
    chk(o_nrd == 1 && o_edge == 6, "R9", "fetch misses after invalidate", 32'(o_nrd), 1);
    access(2'd2, 32'h0000_7000, 0, 2, 0);
    chk(o_nrd == 1 && o_edge == 6, "R9", "data read misses after invalidate", 32'(o_nrd), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; inval = 1'b0; req_valid = 1'b0; req_kind = 2'd0;
    req_addr = '0; req_wdata = '0; l2_fill_valid = 1'b0; l2_fill_line = '0;
    salt = 32'hA5A5_0000;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    t_reset();
    t_first_miss();
    t_fetch_hit();
    t_split();
    t_slow_l2();
    t_internal();
    t_write_hit();
    salt = 32'h0F0F_1111;
    t_write_miss();
    t_busy_ignore();
    t_stray_fill();
    t_inval();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule